// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is the serial control port of a receiver front end. An external controller reaches a small, sparse bank of 8-bit configuration registers over a standard I2C bus. The block never masters the bus and never stretches the clock. It oversamples SCL and SDA with a fast system clock and cleans both lines. It finds START, repeated START and STOP conditions and compares the first byte with a fixed 7-bit device address. It then moves exactly one data byte: a write carries a register index and a value, and a read sets the index and then uses a repeated START to fetch one byte.

The writable registers drive the block's output ports directly, so the analog settings follow every write. Register 15 is a read-only status byte. It shows the loss-of-signal level that is in effect: either the level programmed in register 11 or a built-in default. A clock-off control bit, combined with an external disable pin, makes the slave deaf to the bus. The block drives SDA low only for acknowledge slots and read data bits. The pad logic turns `sda_oe` into an open-drain pull-down.

Top module: `cfg_i2c_slave`

## Requirements
- R1: The slave acknowledges only the device address 7'b1000100, sent MSB first with the direction bit (0 = write, 1 = read) last. It acknowledges by holding SDA low through the whole high phase of the ninth SCL pulse. For any other address it never pulls SDA low and ignores the rest of the transaction.
- R2: The sequence START, address+W, index byte, data byte, STOP stores the data byte in the indexed writable register, and that register's output port shows it. All three bytes are acknowledged.
- R3: The sequence START, address+W, index byte, repeated START, address+R returns the indexed register MSB first on the eight following SCL pulses. The slave then releases SDA for the master's acknowledge bit.
- R4: Only one data byte moves per transaction. In a write, any byte after the first data byte is not acknowledged and changes no register, and the register index never increments.
- R5: Indices 0, 1, 2, 3, 7, 11, 12 and 13 are read/write. A write to any other index is acknowledged and discarded, and a read of an index other than those and 15 returns 0x00.
- R6: Index 15 is read-only. Bit 7 reads 0. Bits 6..0 equal register 11 bits 6..0 when register 11 bit 7 is 1, and 0x40 otherwise. `level_o` carries the same 7-bit value.
- R7: After reset, register 3 holds 0x02 and every other register holds 0x00. Index 15 reads 0x40, and `sda_oe` is 0.
- R8: A STOP or START at any bit position aborts the current transfer. A partly received data byte is not written, and the next transaction starts cleanly.
- R9: While register 0 bit 5 is 1 and `dis_i` is high, the slave ignores all bus activity: it does not acknowledge and writes nothing. With either condition removed, it works normally.
- R10: `sda_oe` is 0 whenever the slave is idle and after every completed transaction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 20 times the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line, as seen at the pad |
| sda_i | input | 1 | Bus data line, as seen at the pad |
| dis_i | input | 1 | External disable pin; together with register 0 bit 5 it mutes the bus port |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge or read data 0) |
| ctrl_o | output | 8 | Register 0 (control bits; bit 5 = clock-off enable) |
| thresh_o | output | 8 | Register 1 (input threshold setting) |
| xpoint_o | output | 8 | Register 2 (cross-point range and de-emphasis) |
| ampl_o | output | 8 | Register 3 (output amplitude code) |
| rxopt_o | output | 8 | Register 7 (receiver optimisation) |
| lvl_o | output | 8 | Register 11 (bit 7 select, bits 6..0 level) |
| mask_fall_o | output | 8 | Register 12 (falling-edge mask enable and time) |
| mask_rise_o | output | 8 | Register 13 (rising-edge mask enable and time) |
| level_o | output | 7 | Loss-of-signal level in effect (same as index 15 bits 6..0) |

## Verification
Every index from 0 to 15 and one index beyond the map is read straight after reset and again after a write sweep with distinct values. The sweep separates real storage, discarded writes and the computed status byte. The status byte is then tried with the select bit clear and set, and with a direct write to it. Malformed traffic covers a wrong device address, a write with a second data byte, STOP in the middle of a byte and a repeated START in the middle of a data byte. Each of these would leave a different register trace if the state machine resynchronised wrongly. The disable path is driven with only the pin high, and then with the pin and the control bit both set, to show that both are needed.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;

  localparam int unsigned DW  = 8;
  localparam int unsigned NRW = 8;

  localparam int unsigned CTRL_K = 0;
  localparam int unsigned AMP_K  = 3;
  localparam int unsigned LVL_K  = 5;
  localparam int unsigned CLK_OFF_BIT = 5;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_REG,
    ST_REG_ACK,
    ST_WDAT,
    ST_WDAT_ACK,
    ST_RDAT,
    ST_RDAT_ACK,
    ST_WAIT
  } link_state_t;

  // bus index of the k-th writable register
  function automatic logic [DW-1:0] rw_addr(input int unsigned k);
    case (k)
      0:       return 8'd0;
      1:       return 8'd1;
      2:       return 8'd2;
      3:       return 8'd3;
      4:       return 8'd7;
      5:       return 8'd11;
      6:       return 8'd12;
      default: return 8'd13;
    endcase
  endfunction

endpackage

// File: rtl/cfg_i2c_deglitch.sv
module cfg_i2c_deglitch #(
  parameter int unsigned SYNC = 2,
  parameter int unsigned FILT = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);

  logic [SYNC-1:0] sync_q;
  logic [FILT-1:0] hist_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      hist_q <= '1;
      dout   <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC-2:0], din};
      hist_q <= {hist_q[FILT-2:0], sync_q[SYNC-1]};
      if (&hist_q)
        dout <= 1'b1;
      else if (~|hist_q)
        dout <= 1'b0;
    end
  end

endmodule

// File: rtl/cfg_i2c_link.sv
module cfg_i2c_link
  import cfg_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1000100
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl,
  input  logic          sda,
  input  logic          hold,
  input  logic [DW-1:0] rd_data,
  output logic          sda_oe,
  output logic          wr_stb,
  output logic [DW-1:0] wr_data,
  output logic [DW-1:0] ptr,
  output logic          idle
);

  localparam int unsigned CW = $clog2(DW + 1);
  localparam logic [CW-1:0] LAST = CW'(DW);

  link_state_t   state_q;
  logic          scl_q, sda_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] rx_q;
  logic [DW-1:0] tx_q;
  logic          rw_q;

  logic scl_r, scl_f, start_c, stop_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  assign scl_r   = ~hold &  scl & ~scl_q;
  assign scl_f   = ~hold & ~scl &  scl_q;
  assign start_c = ~hold &  scl &  scl_q &  sda_q & ~sda;
  assign stop_c  = ~hold &  scl &  scl_q & ~sda_q &  sda;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      rw_q    <= 1'b0;
      ptr     <= '0;
      sda_oe  <= 1'b0;
      wr_stb  <= 1'b0;
      wr_data <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (stop_c) begin
        state_q <= ST_IDLE;
        sda_oe  <= 1'b0;
      end else if (start_c) begin
        state_q <= ST_DEV;
        cnt_q   <= '0;
        sda_oe  <= 1'b0;
      end else begin
        case (state_q)
          ST_DEV, ST_REG, ST_WDAT: begin
            if (scl_r) begin
              rx_q  <= {rx_q[DW-2:0], sda};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_f && cnt_q == LAST) begin
              cnt_q <= '0;
              case (state_q)
                ST_DEV: begin
                  if (rx_q[DW-1:1] == DEV_ADDR) begin
                    sda_oe  <= 1'b1;
                    rw_q    <= rx_q[0];
                    state_q <= ST_DEV_ACK;
                  end else begin
                    state_q <= ST_WAIT;
                  end
                end
                ST_REG: begin
                  ptr     <= rx_q;
                  sda_oe  <= 1'b1;
                  state_q <= ST_REG_ACK;
                end
                default: begin
                  wr_stb  <= 1'b1;
                  wr_data <= rx_q;
                  sda_oe  <= 1'b1;
                  state_q <= ST_WDAT_ACK;
                end
              endcase
            end
          end
          ST_DEV_ACK: begin
            if (scl_f) begin
              if (rw_q) begin
                sda_oe  <= ~rd_data[DW-1];
                tx_q    <= {rd_data[DW-2:0], 1'b0};
                state_q <= ST_RDAT;
              end else begin
                sda_oe  <= 1'b0;
                state_q <= ST_REG;
              end
            end
          end
          ST_REG_ACK: begin
            if (scl_f) begin
              sda_oe  <= 1'b0;
              state_q <= ST_WDAT;
            end
          end
          ST_WDAT_ACK: begin
            if (scl_f) begin
              sda_oe  <= 1'b0;
              state_q <= ST_WAIT;
            end
          end
          ST_RDAT: begin
            if (scl_r) begin
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_f) begin
              if (cnt_q == LAST) begin
                sda_oe  <= 1'b0;
                cnt_q   <= '0;
                state_q <= ST_RDAT_ACK;
              end else begin
                sda_oe <= ~tx_q[DW-1];
                tx_q   <= {tx_q[DW-2:0], 1'b0};
              end
            end
          end
          ST_RDAT_ACK: begin
            if (scl_f) state_q <= ST_WAIT;
          end
          default: ;
        endcase
      end
    end
  end

  assign idle = (state_q == ST_IDLE);

endmodule

// File: rtl/cfg_i2c_regs.sv
module cfg_i2c_regs
  import cfg_i2c_pkg::*;
#(
  parameter logic [DW-1:0] AMP_RST     = 8'h02,
  parameter logic [6:0]    DEF_LEVEL   = 7'h40,
  parameter logic [DW-1:0] STATUS_ADDR = 8'd15
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_stb,
  input  logic [DW-1:0]           wr_addr,
  input  logic [DW-1:0]           wr_data,
  input  logic [DW-1:0]           rd_addr,
  output logic [DW-1:0]           rd_data,
  output logic [NRW-1:0][DW-1:0]  cfg_o,
  output logic [6:0]              sel_level
);

  for (genvar k = 0; k < NRW; k++) begin : g_cfg
    localparam logic [DW-1:0] RST_V   = (k == AMP_K) ? AMP_RST : '0;
    localparam logic [DW-1:0] MY_ADDR = rw_addr(k);
    logic [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)
        q <= RST_V;
      else if (wr_stb && wr_addr == MY_ADDR)
        q <= wr_data;
    end
    assign cfg_o[k] = q;
  end

  assign sel_level = cfg_o[LVL_K][DW-1] ? cfg_o[LVL_K][6:0] : DEF_LEVEL;

  always_comb begin
    rd_data = '0;
    if (rd_addr == STATUS_ADDR)
      rd_data = {1'b0, sel_level};
    for (int k = 0; k < NRW; k++) begin
      if (rd_addr == rw_addr(k))
        rd_data = cfg_o[k];
    end
  end

endmodule

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave
  import cfg_i2c_pkg::*;
#(
  parameter logic [6:0]    DEV_ADDR    = 7'b1000100,
  parameter int unsigned   SYNC_STAGES = 2,
  parameter int unsigned   FILT_LEN    = 3,
  parameter logic [DW-1:0] AMP_RST     = 8'h02,
  parameter logic [6:0]    DEF_LEVEL   = 7'h40
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       dis_i,
  output logic       sda_oe,
  output logic [7:0] ctrl_o,
  output logic [7:0] thresh_o,
  output logic [7:0] xpoint_o,
  output logic [7:0] ampl_o,
  output logic [7:0] rxopt_o,
  output logic [7:0] lvl_o,
  output logic [7:0] mask_fall_o,
  output logic [7:0] mask_rise_o,
  output logic [6:0] level_o
);

  logic [1:0] raw_w, flt_w;
  assign raw_w = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    cfg_i2c_deglitch #(
      .SYNC (SYNC_STAGES),
      .FILT (FILT_LEN)
    ) u_dg (
      .clk  (clk),
      .rst  (rst),
      .din  (raw_w[g]),
      .dout (flt_w[g])
    );
  end

  logic [1:0] dis_q;
  always_ff @(posedge clk) begin
    if (rst) dis_q <= '0;
    else     dis_q <= {dis_q[0], dis_i};
  end

  logic [NRW-1:0][DW-1:0] cfg_w;
  logic          ck_hold;
  logic          wr_stb, link_idle;
  logic [DW-1:0] wr_data, ptr, rd_data;
  logic [6:0]    sel_level;

  assign ck_hold = cfg_w[CTRL_K][CLK_OFF_BIT] & dis_q[1];

  cfg_i2c_link #(
    .DEV_ADDR (DEV_ADDR)
  ) u_link (
    .clk     (clk),
    .rst     (rst),
    .scl     (flt_w[1]),
    .sda     (flt_w[0]),
    .hold    (ck_hold),
    .rd_data (rd_data),
    .sda_oe  (sda_oe),
    .wr_stb  (wr_stb),
    .wr_data (wr_data),
    .ptr     (ptr),
    .idle    (link_idle)
  );

  cfg_i2c_regs #(
    .AMP_RST   (AMP_RST),
    .DEF_LEVEL (DEF_LEVEL)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_stb    (wr_stb),
    .wr_addr   (ptr),
    .wr_data   (wr_data),
    .rd_addr   (ptr),
    .rd_data   (rd_data),
    .cfg_o     (cfg_w),
    .sel_level (sel_level)
  );

  assign ctrl_o      = cfg_w[0];
  assign thresh_o    = cfg_w[1];
  assign xpoint_o    = cfg_w[2];
  assign ampl_o      = cfg_w[3];
  assign rxopt_o     = cfg_w[4];
  assign lvl_o       = cfg_w[5];
  assign mask_fall_o = cfg_w[6];
  assign mask_rise_o = cfg_w[7];
  assign level_o     = sel_level;

endmodule

// File: rtl/cfg_i2c_slave_chk.sv
module cfg_i2c_slave_chk #(
  parameter logic [6:0] DEF_LEVEL = 7'h40
) (
  input logic       clk,
  input logic       rst,
  input logic       sda_oe,
  input logic       hold,
  input logic       link_idle,
  input logic       wr_stb,
  input logic [7:0] wr_addr,
  input logic [7:0] wr_data,
  input logic [7:0] ampl,
  input logic [6:0] level
);

  AST_MUTE_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    (hold && !sda_oe) |=> !sda_oe);  // R9

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    link_idle |-> !sda_oe);  // R10

  AST_ONE_WRITE_PULSE: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !wr_stb);  // R4

  AST_AMPL_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    !(wr_stb && wr_addr == 8'd3) |=> $stable(ampl));  // R2

  AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && wr_addr == 8'd11) |=>
      (level == ($past(wr_data[7]) ? $past(wr_data[6:0]) : DEF_LEVEL)));  // R6

endmodule

bind cfg_i2c_slave cfg_i2c_slave_chk #(.DEF_LEVEL(DEF_LEVEL)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sda_oe    (sda_oe),
  .hold      (ck_hold),
  .link_idle (link_idle),
  .wr_stb    (wr_stb),
  .wr_addr   (ptr),
  .wr_data   (wr_data),
  .ampl      (ampl_o),
  .level     (level_o)
);

// File: tb/cfg_i2c_slave_tb_top.sv
module cfg_i2c_slave_tb_top;

  localparam logic [6:0] ADDR = 7'b1000100;
  localparam int Q    = 8;
  localparam int HIGH = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1, dis = 1'b0;
  logic sda_oe;
  logic [7:0] ctrl_o, thresh_o, xpoint_o, ampl_o, rxopt_o, lvl_o, mask_fall_o, mask_rise_o;
  logic [6:0] level_o;
  wire line = sda_m & ~sda_oe;

  cfg_i2c_slave dut_i (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(line), .dis_i(dis),
    .sda_oe(sda_oe), .ctrl_o(ctrl_o), .thresh_o(thresh_o), .xpoint_o(xpoint_o),
    .ampl_o(ampl_o), .rxopt_o(rxopt_o), .lvl_o(lvl_o), .mask_fall_o(mask_fall_o),
    .mask_rise_o(mask_rise_o), .level_o(level_o)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [7:0] mdl [16];

  function automatic bit mdl_rw(int a);
    return (a == 0 || a == 1 || a == 2 || a == 3 || a == 7 || a == 11 || a == 12 || a == 13);
  endfunction

  function automatic logic [7:0] mdl_read(int a);
    if (a > 15) return 8'h00;
    if (a == 15) return mdl[11][7] ? {1'b0, mdl[11][6:0]} : 8'h40;
    if (mdl_rw(a)) return mdl[a];
    return 8'h00;
  endfunction

  task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic wclk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_bit(input logic b, output logic seen);
    sda_m = b;
    wclk(Q);
    scl_m = 1'b1;
    wclk(HIGH / 2);
    seen = line;
    wclk(HIGH / 2);
    if (line !== seen) seen = 1'bx;
    scl_m = 1'b0;
    wclk(Q);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wclk(Q);
    scl_m = 1'b1; wclk(HIGH);
    sda_m = 1'b0; wclk(HIGH);
    scl_m = 1'b0; wclk(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wclk(Q);
    scl_m = 1'b1; wclk(HIGH);
    sda_m = 1'b1; wclk(4 * Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
    bus_bit(1'b1, s);
    ack = (s === 1'b0);
  endtask

  task automatic recv_byte(output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, s);
      b[i] = s;
    end
    bus_bit(1'b1, s);
  endtask

  task automatic write_txn(input logic [7:0] a, input logic [7:0] d, output logic [2:0] acks);
    bus_start();
    send_byte({ADDR, 1'b0}, acks[2]);
    send_byte(a, acks[1]);
    send_byte(d, acks[0]);
    bus_stop();
  endtask

  task automatic read_txn(input logic [7:0] a, output logic [7:0] d, output logic [2:0] acks);
    bus_start();
    send_byte({ADDR, 1'b0}, acks[2]);
    send_byte(a, acks[1]);
    bus_start();
    send_byte({ADDR, 1'b1}, acks[0]);
    recv_byte(d);
    bus_stop();
  endtask

  task automatic do_write(string req, int a, logic [7:0] d);
    logic [2:0] k;
    write_txn(8'(a), d, k);
    check(req, $sformatf("write acks idx %0d", a), {5'd0, k}, 8'h07);
    if (mdl_rw(a)) mdl[a] = d;
    check("R10", "released after write", {7'd0, sda_oe}, 8'h00);
  endtask

  task automatic do_read(string req, int a);
    logic [2:0] k;
    logic [7:0] d;
    read_txn(8'(a), d, k);
    check(req, $sformatf("read acks idx %0d", a), {5'd0, k}, 8'h07);
    check(req, $sformatf("read data idx %0d", a), d, mdl_read(a));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [2:0] k;
    logic [7:0] d;
    logic s;
    for (int i = 0; i < 16; i++) mdl[i] = (i == 3) ? 8'h02 : 8'h00;
    wclk(10);
    rst = 1'b0;
    wclk(10);

    // R7 reset state at the ports
    check("R7", "sda_oe after reset", {7'd0, sda_oe}, 8'h00);
    check("R7", "ampl after reset", ampl_o, 8'h02);
    check("R7", "ctrl after reset", ctrl_o, 8'h00);
    check("R7", "level after reset", {1'b0, level_o}, 8'h40);

    // R7 / R5 / R3: read every index and one beyond the map
    for (int a = 0; a < 16; a++) do_read("R7", a);
    do_read("R5", 32);

    // R2 / R5: write sweep with distinct values, bit 5 of reg 0 cleared
    for (int a = 0; a < 16; a++) begin
      logic [7:0] v;
      v = 8'((a * 29 + 90) & 8'hFF);
      if (a == 0) v = v & 8'hDF;
      do_write("R2", a, v);
    end
    do_write("R5", 40, 8'hEE);
    check("R2", "ctrl port", ctrl_o, mdl[0]);
    check("R2", "thresh port", thresh_o, mdl[1]);
    check("R2", "xpoint port", xpoint_o, mdl[2]);
    check("R2", "ampl port", ampl_o, mdl[3]);
    check("R2", "rxopt port", rxopt_o, mdl[7]);
    check("R2", "lvl port", lvl_o, mdl[11]);
    check("R2", "mask fall port", mask_fall_o, mdl[12]);
    check("R2", "mask rise port", mask_rise_o, mdl[13]);
    for (int a = 0; a < 16; a++) do_read("R3", a);
    do_read("R5", 40);

    // R6 status byte both ways, and write to it discarded
    do_write("R6", 11, 8'h00);
    do_read("R6", 15);
    check("R6", "level port default", {1'b0, level_o}, 8'h40);
    do_write("R6", 11, 8'hAB);
    do_read("R6", 15);
    check("R6", "level port selected", {1'b0, level_o}, 8'h2B);
    do_write("R6", 15, 8'hFF);
    do_read("R6", 15);

    // R1 wrong address: no acknowledge, no effect
    bus_start();
    send_byte({7'b1000101, 1'b0}, k[2]);
    send_byte(8'd1, k[1]);
    send_byte(8'h99, k[0]);
    bus_stop();
    check("R1", "acks for wrong address", {5'd0, k}, 8'h00);
    do_read("R1", 1);

    // R4 second data byte refused, no auto-increment
    bus_start();
    send_byte({ADDR, 1'b0}, k[2]);
    send_byte(8'd12, k[1]);
    send_byte(8'h3C, k[0]);
    check("R4", "first data byte acks", {5'd0, k}, 8'h07);
    send_byte(8'hC3, k[0]);
    bus_stop();
    check("R4", "second data byte ack", {7'd0, k[0]}, 8'h00);
    mdl[12] = 8'h3C;
    do_read("R4", 12);
    do_read("R4", 13);

    // R8 STOP in mid data byte
    bus_start();
    send_byte({ADDR, 1'b0}, k[2]);
    send_byte(8'd1, k[1]);
    bus_bit(1'b0, s); bus_bit(1'b1, s); bus_bit(1'b0, s);
    bus_stop();
    do_read("R8", 1);

    // R8 repeated START in mid data byte turns into a read
    bus_start();
    send_byte({ADDR, 1'b0}, k[2]);
    send_byte(8'd2, k[1]);
    for (int i = 0; i < 5; i++) bus_bit(1'b0, s);
    bus_start();
    send_byte({ADDR, 1'b1}, k[0]);
    recv_byte(d);
    bus_stop();
    check("R8", "acks around restart", {5'd0, k}, 8'h07);
    check("R8", "read after restart", d, mdl[2]);
    check("R10", "released after read", {7'd0, sda_oe}, 8'h00);

    // R9 pin alone does not mute
    dis = 1'b1; wclk(10);
    do_write("R9", 1, 8'h5D);
    do_read("R9", 1);
    dis = 1'b0; wclk(10);
    do_write("R9", 0, 8'h20);
    dis = 1'b1; wclk(10);
    write_txn(8'd1, 8'h77, k);
    check("R9", "acks while muted", {5'd0, k}, 8'h00);
    check("R9", "thresh while muted", thresh_o, mdl[1]);
    dis = 1'b0; wclk(10);
    bus_stop();
    do_read("R9", 1);
    do_write("R9", 0, 8'h00);
    check("R10", "released at end", {7'd0, sda_oe}, 8'h00);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule